// File: doc/BRIEF.md
# Next Program Counter Unit

This block holds the program counter of a 32-bit processor whose instructions are all four bytes long, and works out where the next fetch comes from. Each cycle it receives the fetched instruction word, a strobe that marks the word as valid, and the two register operands read for it. From these it picks the following address. The choices are the next sequential word, an absolute jump inside the current 256 MB region, a jump to an address held in a register, or a branch relative to the PC that depends on whether the two operands are equal.

The new PC and a flag that reports a control transfer are registered together. They change only on cycles where the strobe is high. The register file and the instruction memory sit outside the block. The block has no delay slots, no exceptions and no check on target alignment.

Top module: `npc_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `pc` loads the parameter `RESET_VEC` (0x00000000 by default) and `taken` clears to 0.
- R2: On an edge where `instr_valid` is low, `pc` keeps its value and `taken` becomes 0.
- R3: A valid instruction that is not a control transfer sets `pc` to `pc + 4` (modulo 2^32) and `taken` to 0.
- R4: Opcode field `instr[31:26]` = 2 is an absolute jump. The next `pc` is `{pc[31:28], instr[25:0], 2'b00}`.
- R5: Opcode 0 with function field `instr[5:0]` = 8 is a register jump. The next `pc` is `rs_val` exactly as given, with no shift. `rs_val` is the operand read from the register named by `instr[25:21]`.
- R6: Opcode 4 branches when `rs_val == rt_val`. Opcode 5 branches when they differ. `rt_val` is the operand read from the register named by `instr[20:16]`. When the condition fails, the next `pc` is `pc + 4`.
- R7: A taken branch goes to `pc + 4 + (sign-extended instr[15:0] << 2)`. The word 0x14850002 at 0x1000 with unequal operands goes to 0x100C.
- R8: Branch reach covers the full signed offset range. An offset of 0x8000 lands 131068 bytes below the branch, and an offset of 0x7FFF lands 131072 bytes above it.
- R9: Opcode 0 with any other function value, and every opcode other than 0, 2, 4 and 5, falls through as in R3.
- R10: After a valid jump, a valid register jump, or a branch whose condition holds, `taken` is 1 for the cycle that follows. In every other case it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Marks `instr` and the operands as valid this cycle |
| instr | input | 32 | Fetched instruction word at address `pc` |
| rs_val | input | 32 | Operand read for field instr[25:21] |
| rt_val | input | 32 | Operand read for field instr[20:16] |
| pc | output | 32 | Registered program counter |
| taken | output | 1 | Registered control-transfer flag |

## Verification
The bench goes after the sign of the branch offset at both extremes. A design that zero-extends the offset sends an offset of 0x8000 forward instead of back. The bench also places jumps in an upper address region: a design that drops PC[31:28] lands in the bottom 256 MB. A register jump with a non-multiple-of-four operand catches a design that scales the register, and function values close to 8 catch a design that decodes only part of the function field. The known encoding at 0x1000 catches a branch target computed from the branch address instead of PC+4. Cycles with the strobe low catch a PC that advances when it should hold.

// File: rtl/npc_pkg.sv
package npc_pkg;

    localparam int XLEN       = 32;
    localparam int OPC_W      = 6;
    localparam int FUN_W      = 6;
    localparam int JIDX_W     = 26;
    localparam int IMM_W      = 16;
    localparam int REGION_W   = XLEN - JIDX_W - 2;
    localparam int ILEN_BYTES = 4;

    localparam logic [OPC_W-1:0] OPC_SPECIAL = 6'd0;
    localparam logic [OPC_W-1:0] OPC_JUMP    = 6'd2;
    localparam logic [OPC_W-1:0] OPC_BREQ    = 6'd4;
    localparam logic [OPC_W-1:0] OPC_BRNE    = 6'd5;
    localparam logic [FUN_W-1:0] FUN_REGJMP  = 6'd8;

    typedef enum logic [2:0] {
        XFER_SEQ,
        XFER_JUMP,
        XFER_REG,
        XFER_BREQ,
        XFER_BRNE
    } xfer_e;

    typedef struct packed {
        logic [XLEN-1:0] pc;
        logic            taken;
    } npc_state_t;

endpackage

// File: rtl/npc_decode.sv
module npc_decode
    import npc_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    input  logic [FUN_W-1:0] funct,
    output xfer_e            kind
);
    always_comb begin
        kind = XFER_SEQ;
        unique case (opcode)
            OPC_SPECIAL: kind = (funct == FUN_REGJMP) ? XFER_REG : XFER_SEQ;
            OPC_JUMP:    kind = XFER_JUMP;
            OPC_BREQ:    kind = XFER_BREQ;
            OPC_BRNE:    kind = XFER_BRNE;
            default:     kind = XFER_SEQ;
        endcase
    end
endmodule

// File: rtl/npc_target.sv
module npc_target
    import npc_pkg::*;
(
    input  logic [XLEN-1:0]   pc_cur,
    input  logic [JIDX_W-1:0] jidx,
    input  logic [IMM_W-1:0]  imm,
    output logic [XLEN-1:0]   seq_tgt,
    output logic [XLEN-1:0]   jump_tgt,
    output logic [XLEN-1:0]   br_tgt
);
    localparam int EXT_W = XLEN - IMM_W - 2;

    logic [XLEN-1:0] br_disp;

    always_comb begin
        seq_tgt  = pc_cur + XLEN'(ILEN_BYTES);
        jump_tgt = {pc_cur[XLEN-1 -: REGION_W], jidx, 2'b00};
        br_disp  = {{EXT_W{imm[IMM_W-1]}}, imm, 2'b00};
        br_tgt   = seq_tgt + br_disp;
    end
endmodule

// File: rtl/npc_compare.sv
module npc_compare
    import npc_pkg::*;
(
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic            same
);
    always_comb same = ((a ^ b) == '0);
endmodule

// File: rtl/npc_unit.sv
module npc_unit
    import npc_pkg::*;
#(
    parameter logic [31:0] RESET_VEC = 32'h0000_0000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        instr_valid,
    input  logic [31:0] instr,
    input  logic [31:0] rs_val,
    input  logic [31:0] rt_val,
    output logic [31:0] pc,
    output logic        taken
);
    npc_state_t      state_d, state_q;
    xfer_e           kind;
    logic            ops_same;
    logic [XLEN-1:0] seq_tgt, jump_tgt, br_tgt;

    npc_decode u_decode (
        .opcode (instr[31:26]),
        .funct  (instr[5:0]),
        .kind   (kind)
    );

    npc_compare u_cmp (
        .a    (rs_val),
        .b    (rt_val),
        .same (ops_same)
    );

    npc_target u_tgt (
        .pc_cur   (state_q.pc),
        .jidx     (instr[25:0]),
        .imm      (instr[15:0]),
        .seq_tgt  (seq_tgt),
        .jump_tgt (jump_tgt),
        .br_tgt   (br_tgt)
    );

    always_comb begin
        state_d       = state_q;
        state_d.taken = 1'b0;
        if (instr_valid) begin
            state_d.pc = seq_tgt;
            unique case (kind)
                XFER_JUMP: begin
                    state_d.pc    = jump_tgt;
                    state_d.taken = 1'b1;
                end
                XFER_REG: begin
                    state_d.pc    = rs_val;
                    state_d.taken = 1'b1;
                end
                XFER_BREQ: if (ops_same) begin
                    state_d.pc    = br_tgt;
                    state_d.taken = 1'b1;
                end
                XFER_BRNE: if (!ops_same) begin
                    state_d.pc    = br_tgt;
                    state_d.taken = 1'b1;
                end
                default: state_d.pc = seq_tgt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q.pc    <= RESET_VEC;
            state_q.taken <= 1'b0;
        end else begin
            state_q <= state_d;
        end
    end

    assign pc    = state_q.pc;
    assign taken = state_q.taken;
endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk #(
    parameter logic [31:0] RESET_VEC = 32'h0000_0000
) (
    input logic        clk,
    input logic        rst,
    input logic        instr_valid,
    input logic [31:0] instr,
    input logic [31:0] rs_val,
    input logic [31:0] rt_val,
    input logic [31:0] pc,
    input logic        taken
);
    logic is_ctl;
    assign is_ctl = (instr[31:26] == 6'd2) || (instr[31:26] == 6'd4) ||
                    (instr[31:26] == 6'd5) ||
                    ((instr[31:26] == 6'd0) && (instr[5:0] == 6'd8));

    AST_RESET_VEC: assert property (@(posedge clk) rst |=> (pc == RESET_VEC) && !taken); // R1

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !instr_valid |=> $stable(pc) && !taken); // R2

    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && !is_ctl) |=> (pc == $past(pc) + 32'd4) && !taken); // R3

    AST_JUMP_REGION: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && instr[31:26] == 6'd2) |=>
        (pc[31:28] == $past(pc[31:28])) && (pc[27:2] == $past(instr[25:0])) && taken); // R4

    AST_REG_JUMP: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && instr[31:26] == 6'd0 && instr[5:0] == 6'd8) |=>
        (pc == $past(rs_val)) && taken); // R5

    AST_BR_NOT_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && ((instr[31:26] == 6'd4 && rs_val != rt_val) ||
                         (instr[31:26] == 6'd5 && rs_val == rt_val))) |=>
        (pc == $past(pc) + 32'd4) && !taken); // R6

    AST_BR_TARGET: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && ((instr[31:26] == 6'd4 && rs_val == rt_val) ||
                         (instr[31:26] == 6'd5 && rs_val != rt_val))) |=>
        (pc == $past(pc) + 32'd4 + {{14{$past(instr[15])}}, $past(instr[15:0]), 2'b00}) && taken); // R7
endmodule

bind npc_unit npc_unit_chk #(.RESET_VEC(RESET_VEC)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .instr_valid (instr_valid),
    .instr       (instr),
    .rs_val      (rs_val),
    .rt_val      (rt_val),
    .pc          (pc),
    .taken       (taken)
);

// File: tb/npc_unit_tb.sv
`timescale 1ns/1ps
module npc_unit_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        instr_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] rs_val = '0;
    logic [31:0] rt_val = '0;
    logic [31:0] pc;
    logic        taken;

    int n_checks = 0;
    int n_fail   = 0;
    logic [31:0] exp_pc;
    logic        exp_tk;

    always #2 clk = ~clk;

    npc_unit u_dut (
        .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr(instr),
        .rs_val(rs_val), .rt_val(rt_val), .pc(pc), .taken(taken)
    );

    function automatic logic [31:0] model_pc(input logic [31:0] p, input logic [31:0] w,
                                             input logic [31:0] a, input logic [31:0] b,
                                             output logic tk);
        logic [31:0] seq;
        logic [31:0] off;
        seq = p + 32'd4;
        off = {{14{w[15]}}, w[15:0], 2'b00};
        tk  = 1'b1;
        if (w[31:26] == 6'd2)                          return {p[31:28], w[25:0], 2'b00};
        if (w[31:26] == 6'd0 && w[5:0] == 6'd8)        return a;
        if (w[31:26] == 6'd4 && a == b)                return seq + off;
        if (w[31:26] == 6'd5 && a != b)                return seq + off;
        tk = 1'b0;
        return seq;
    endfunction

    task automatic check(input string req);
        n_checks++;
        if (pc !== exp_pc || taken !== exp_tk) begin
            n_fail++;
            $display("FAIL %s: pc=%h taken=%b expected pc=%h taken=%b",
                     req, pc, taken, exp_pc, exp_tk);
        end
    endtask

    // Drive one cycle at the current negedge, then check after the next posedge.
    task automatic step(input logic v, input logic [31:0] w, input logic [31:0] a,
                        input logic [31:0] b, input string req);
        logic tk;
        instr_valid = v; instr = w; rs_val = a; rt_val = b;
        if (v) exp_pc = model_pc(exp_pc, w, a, b, tk);
        else   tk = 1'b0;
        exp_tk = tk;
        @(negedge clk);
        check(req);
    endtask

    initial begin
        #200000;
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: pc=%h taken=%b expected completion", pc, taken);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [31:0] rstate;
        rstate = $urandom(32'h5eed_0042);
        repeat (2) @(negedge clk);
        exp_pc = 32'h0; exp_tk = 1'b0;
        check("R1 reset");
        rst = 1'b0;

        step(1'b1, 32'h0000_0020, 0, 0, "R3 sequential");
        step(1'b0, 32'h0800_0100, 0, 0, "R2 idle jump ignored");
        step(1'b1, 32'h0000_0008, 32'h0000_1000, 0, "R5 reg jump to 0x1000");
        step(1'b1, 32'h1485_0002, 32'd11, 32'd22, "R7 known bne to 0x100C");
        step(1'b1, 32'h1485_0002, 32'd7, 32'd7, "R6 bne not taken");
        step(1'b1, 32'h1000_0003, 32'd9, 32'd9, "R6 beq taken");
        step(1'b1, 32'h1000_0003, 32'd9, 32'd8, "R6 beq not taken");
        step(1'b1, 32'h0000_0009, 32'h1234_5678, 0, "R9 funct 9 falls through");
        step(1'b1, 32'h0000_000C, 32'h1234_5678, 0, "R9 funct 12 falls through");
        step(1'b1, 32'h0000_0008, 32'h4000_0000, 0, "R5 reg jump high");
        step(1'b1, 32'h1000_8000, 32'd1, 32'd1, "R8 max backward reach");
        if (exp_pc !== 32'h4000_0000 - 32'd131068) begin
            n_fail++;
            $display("FAIL R8: model=%h expected=%h", exp_pc, 32'h4000_0000 - 32'd131068);
        end
        step(1'b1, 32'h0000_0008, 32'h5000_0000, 0, "R5 reg jump");
        step(1'b1, 32'h1400_7FFF, 32'd1, 32'd2, "R8 max forward reach");
        step(1'b1, 32'h0000_0008, 32'hA000_0000, 0, "R5 reg jump upper region");
        step(1'b1, 32'h0BFF_FFFF, 0, 0, "R4 jump keeps region");
        step(1'b1, 32'h0000_0008, 32'h0000_0003, 0, "R5 unscaled odd target");
        step(1'b1, 32'hFC00_0000, 0, 0, "R9 unknown opcode");
        step(1'b0, 32'h0000_0008, 32'hDEAD_BEEF, 0, "R2 idle reg jump ignored");

        for (int i = 0; i < 3000; i++) begin
            logic [31:0] w;
            logic [31:0] a;
            logic [31:0] b;
            logic        v;
            w = $urandom;
            a = $urandom;
            b = ($urandom_range(0, 1) == 1) ? a : $urandom;
            v = ($urandom_range(0, 9) != 0);
            case ($urandom_range(0, 5))
                0: w[31:26] = 6'd2;
                1: begin w[31:26] = 6'd0; w[5:0] = 6'd8; end
                2: w[31:26] = 6'd4;
                3: w[31:26] = 6'd5;
                4: w[31:26] = 6'd0;
                default: ;
            endcase
            step(v, w, a, b, "R10 random mix");
        end

        rst = 1'b1;
        instr_valid = 1'b0;
        @(negedge clk);
        exp_pc = 32'h0; exp_tk = 1'b0;
        check("R1 mid-run reset");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule